// File: doc/BRIEF.md
# Cascadable Interval Timer with Compare Toggle

The block holds two 8-bit up-counters, A and B. Each counter has its own limit register. When a counter equals its limit on an enabled count tick, it wraps to zero on that tick and sets a sticky interrupt flag. The two counters can run as separate 8-bit timers. They can also be joined into one 16-bit counter, with A as the low byte and B as the high byte. In that case the joint limit is {limit B, limit A}, and only the interrupt of A is raised.

Counter A takes its count ticks from one of two places:
- a free-running prescaler of the system clock, giving divide ratios from 2 to 2048;
- an external event pin, which is synchronised and edge-detected.

Every match of A toggles a compare flip-flop. That flip-flop drives a square-wave pin with a 50:50 duty cycle, at a frequency of fclk / (2 · prescale · (limit + 1)).

Software controls the block through a synchronous write port and a combinational read port.

Each counter is run by a three-state controller: `CH_CLEAR`, `CH_HOLD` and `CH_RUN`. The transitions into each state are:
- `CH_RUN` is entered when the run bit is 1.
- `CH_HOLD` is entered when run is 0 and keep is 1. This freezes the count.
- `CH_CLEAR` is entered when both run and keep are 0. This forces the count to zero.

In 16-bit mode, the controller of A governs both bytes.

Register map (3-bit address):

| Addr | Register | Fields |
|------|----------|--------|
| 0 | config A | [2:0] source, [3] keep, [4] run. Bits [7:5] read 0. |
| 1 | config B | [1:0] source, [2] keep, [3] run, [4] wide, [5] pwm_en, [6] pin_en, [7] spare |
| 2 | limit A | |
| 3 | limit B | |
| 4 | count A | Read-only. |
| 5 | count B | Read-only. |
| 6 | flags | [0] = A, [1] = B. Write 1 to clear. |

Top module: `tmr_cascade`

## Requirements
- R1: In 8-bit operation, counter A starts at 0 and advances by one on each enabled tick. A tick taken while it equals limit A returns it to 0 and sets flag A. For a limit L, the count after N ticks is N mod (L+1).
- R2: 16-bit mode is active only when config B source is 2'b11 and config B bit 4 (wide) is 1. In that mode {count B, count A} counts as one 16-bit value and wraps to 0x0000 on the tick taken at {limit B, limit A}. The run and keep bits of config A control both bytes.
- R3: In 16-bit mode a match sets only flag A. Flag B is never set while the mode is active.
- R4: Config A source selects the tick of counter A as follows: 0 → fclk/2, 1 → /4, 2 → /8, 3 → /32, 4 → /128, 5 → /512, 6 → /2048, 7 → a rising edge on `ext_evt`. Prescaler ticks and edge ticks last one cycle each.
- R5: A counter whose run bit is 0 does not count. With keep = 1 it holds its value, and it resumes from that value when run returns to 1. With keep = 0 it is forced to 0.
- R6: Any write to a config register with run = 1 and keep = 0 restarts that counter from 0.
- R7: Each match of counter A toggles the compare flip-flop, whose reset value is 0. The pin therefore changes level every prescale·(limit A + 1) clock cycles.
- R8: `cmp_pin` follows the compare flip-flop only while pin_en (config B bit 6) is 1 and pwm_en (config B bit 5) is 0. Otherwise it is 0.
- R9: After reset, every readable register, both counts, both flags, `irq_a`, `irq_b` and `cmp_pin` are 0.
- R10: Flags stay set until a write to address 6 with a 1 in the flag's bit. Writing 0 leaves the flag set. A match in the same cycle as the clearing write leaves the flag set.
- R11: When 16-bit mode is not active, config B source selects the tick of counter B: 0 → fclk/2, 1 → /8, 2 → /128, 3 → each match of counter A. Counter B sets flag B on its own matches.
- R12: Writes to addresses 4 and 5 do not change the counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ext_evt | input | 1 | External event input, asynchronous |
| irq_a | output | 1 | Interrupt flag of counter A |
| irq_b | output | 1 | Interrupt flag of counter B |
| cmp_pin | output | 1 | Gated compare square wave |

## Verification
The results of the block fall due at different points:
- A clearing or restarting config write takes effect on the counts at the write edge itself.
- A change of run or keep reaches the controller state one edge later.
- An `ext_evt` rise passes through two synchroniser flops and then an edge detector, so its count lands on the third clock edge after the rise.

The bench therefore issues writes at falling edges. It holds every external pulse high and then low for four cycles each, and it reads the counts and flags only after those windows close, at a falling edge.

Timing of the compare pin is measured as the number of falling edges between two consecutive level changes. The free-running prescaler then fixes the expected spacing exactly, whatever its phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CFG_A = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CFG_B = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_LIM_A = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_LIM_B = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CNT_A = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CNT_B = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_FLAG  = 3'd6;

    // Counter A source code that selects the external event edge
    localparam logic [2:0] SRC_A_EXT   = 3'd7;
    // Counter B source code that selects the matches of counter A
    localparam logic [1:0] SRC_B_CHAIN = 2'd3;

    typedef enum logic [1:0] {
        CH_CLEAR = 2'd0,
        CH_HOLD  = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic       run;
        logic       keep;
        logic [2:0] src;
    } cfg_a_t;

    typedef struct packed {
        logic       spare;
        logic       pin_en;
        logic       pwm_en;
        logic       wide;
        logic       run;
        logic       keep;
        logic [1:0] src;
    } cfg_b_t;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output cfg_a_t            cfg_a,
    output cfg_b_t            cfg_b,
    output logic [DW-1:0]     lim_a,
    output logic [DW-1:0]     lim_b,
    output logic              restart_a,
    output logic              restart_b,
    output logic [1:0]        clr_flags
);

    cfg_a_t wr_as_a;
    cfg_b_t wr_as_b;

    assign wr_as_a = cfg_a_t'(wr_data[4:0]);
    assign wr_as_b = cfg_b_t'(wr_data[7:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a <= '0;
            cfg_b <= '0;
            lim_a <= '0;
            lim_b <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CFG_A: cfg_a <= wr_as_a;
                ADR_CFG_B: cfg_b <= wr_as_b;
                ADR_LIM_A: lim_a <= wr_data;
                ADR_LIM_B: lim_b <= wr_data;
                default:   ;
            endcase
        end
    end

    // Restart and flag-clear strobes act on the write edge itself
    always_comb begin
        restart_a = wr_en && (wr_addr == ADR_CFG_A) && wr_as_a.run && !wr_as_a.keep;
        restart_b = wr_en && (wr_addr == ADR_CFG_B) && wr_as_b.run && !wr_as_b.keep;
        clr_flags = (wr_en && (wr_addr == ADR_FLAG)) ? wr_data[1:0] : 2'b00;
    end

endmodule

// File: rtl/tmr_clk_src.sv
module tmr_clk_src
    import tmr_pkg::*;
#(
    parameter int PRE_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_evt,
    input  logic [2:0] src_a,
    input  logic [1:0] src_b,
    output logic       tick_a,
    output logic       tick_b
);

    localparam int NTAP = 7;
    localparam int TAP_SH [NTAP] = '{1, 2, 3, 5, 7, 9, 11};

    logic [PRE_W-1:0] pre_cnt;
    logic [NTAP-1:0]  taps;
    logic [1:0]       sync_q;
    logic             prev_q;
    logic             ext_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + PRE_W'(1);
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << TAP_SH[g]) - 1);
        assign taps[g] = ((pre_cnt & MASK) == MASK);

        assert_tap_single_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            taps[g] |=> !taps[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_evt};
            prev_q <= sync_q[1];
        end
    end

    assign ext_edge = sync_q[1] && !prev_q;

    assert_edge_single_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> !ext_edge);

    always_comb begin
        if (src_a == SRC_A_EXT) tick_a = ext_edge;
        else                    tick_a = taps[src_a];

        unique case (src_b)
            2'd0:        tick_b = taps[0];
            2'd1:        tick_b = taps[2];
            2'd2:        tick_b = taps[4];
            SRC_B_CHAIN: tick_b = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_a_t        cfg_a,
    input  cfg_b_t        cfg_b,
    input  logic [CW-1:0] lim_a,
    input  logic [CW-1:0] lim_b,
    input  logic          restart_a,
    input  logic          restart_b,
    input  logic [1:0]    clr_flags,
    input  logic          tick_a,
    input  logic          tick_b_pre,
    output logic [CW-1:0] cnt_a,
    output logic [CW-1:0] cnt_b,
    output logic          flag_a,
    output logic          flag_b,
    output logic          cmp_ff
);

    localparam int WW = 2 * CW;

    ch_state_e     st_a, st_b, st_a_d, st_b_d;
    logic          wide;
    logic          hit_a, hit_b, tick_b;
    logic [CW-1:0] cnt_a_d, cnt_b_d;
    logic [WW-1:0] wide_cnt, wide_lim;

    assign wide     = (cfg_b.src == SRC_B_CHAIN) && cfg_b.wide;
    assign wide_cnt = {cnt_b, cnt_a};
    assign wide_lim = {lim_b, lim_a};

    function automatic ch_state_e pick_state(input logic run, input logic keep);
        unique casez ({run, keep})
            2'b1?:   return CH_RUN;
            2'b01:   return CH_HOLD;
            2'b00:   return CH_CLEAR;
            default: return CH_CLEAR;
        endcase
    endfunction

    always_comb begin
        st_a_d = pick_state(cfg_a.run, cfg_a.keep);
        st_b_d = pick_state(cfg_b.run, cfg_b.keep);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_a <= CH_CLEAR;
            st_b <= CH_CLEAR;
        end else begin
            st_a <= st_a_d;
            st_b <= st_b_d;
        end
    end

    // Outputs of the state machines: next counts and match strobes
    always_comb begin
        cnt_a_d = cnt_a;
        cnt_b_d = cnt_b;
        hit_a   = 1'b0;
        hit_b   = 1'b0;
        tick_b  = 1'b0;

        if (restart_a) begin
            cnt_a_d = '0;
            if (wide) cnt_b_d = '0;
        end else begin
            unique case (st_a)
                CH_CLEAR: begin
                    cnt_a_d = '0;
                    if (wide) cnt_b_d = '0;
                end
                CH_HOLD: ;
                CH_RUN: begin
                    if (tick_a) begin
                        if (wide) begin
                            if (wide_cnt == wide_lim) begin
                                {cnt_b_d, cnt_a_d} = '0;
                                hit_a = 1'b1;
                            end else begin
                                {cnt_b_d, cnt_a_d} = wide_cnt + WW'(1);
                            end
                        end else if (cnt_a == lim_a) begin
                            cnt_a_d = '0;
                            hit_a   = 1'b1;
                        end else begin
                            cnt_a_d = cnt_a + CW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end

        if (!wide) begin
            tick_b = (cfg_b.src == SRC_B_CHAIN) ? hit_a : tick_b_pre;
            if (restart_b) begin
                cnt_b_d = '0;
            end else begin
                unique case (st_b)
                    CH_CLEAR: cnt_b_d = '0;
                    CH_HOLD:  ;
                    CH_RUN: begin
                        if (tick_b) begin
                            if (cnt_b == lim_b) begin
                                cnt_b_d = '0;
                                hit_b   = 1'b1;
                            end else begin
                                cnt_b_d = cnt_b + CW'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_a  <= '0;
            cnt_b  <= '0;
            flag_a <= 1'b0;
            flag_b <= 1'b0;
            cmp_ff <= 1'b0;
        end else begin
            cnt_a  <= cnt_a_d;
            cnt_b  <= cnt_b_d;
            flag_a <= hit_a | (flag_a & ~clr_flags[0]);
            flag_b <= hit_b | (flag_b & ~clr_flags[1]);
            cmp_ff <= cmp_ff ^ hit_a;
        end
    end

    assert_wrap_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_a == CH_RUN && tick_a && !restart_a && !wide && cnt_a == lim_a)
        |=> (cnt_a == '0 && flag_a));

    assert_wide_wrap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_a == CH_RUN && tick_a && !restart_a && wide && wide_cnt == wide_lim)
        |=> (cnt_a == '0 && cnt_b == '0 && flag_a));

    assert_wide_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !flag_b) |=> !flag_b);

    assert_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_a == CH_HOLD && !restart_a) |=> $stable(cnt_a));

    assert_restart_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        restart_a |=> (cnt_a == '0));

    assert_match_wins_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flag_a);

endmodule

// File: rtl/tmr_cascade.sv
module tmr_cascade
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_evt,
    output logic             irq_a,
    output logic             irq_b,
    output logic             cmp_pin
);

    cfg_a_t           cfg_a;
    cfg_b_t           cfg_b;
    logic [CNT_W-1:0] lim_a, lim_b, cnt_a, cnt_b;
    logic             restart_a, restart_b;
    logic [1:0]       clr_flags;
    logic             tick_a, tick_b_pre;
    logic             flag_a, flag_b, cmp_ff;

    tmr_regs #(.DW(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .lim_a     (lim_a),
        .lim_b     (lim_b),
        .restart_a (restart_a),
        .restart_b (restart_b),
        .clr_flags (clr_flags)
    );

    tmr_clk_src #(.PRE_W(PRE_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_evt (ext_evt),
        .src_a   (cfg_a.src),
        .src_b   (cfg_b.src),
        .tick_a  (tick_a),
        .tick_b  (tick_b_pre)
    );

    tmr_core #(.CW(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_a      (cfg_a),
        .cfg_b      (cfg_b),
        .lim_a      (lim_a),
        .lim_b      (lim_b),
        .restart_a  (restart_a),
        .restart_b  (restart_b),
        .clr_flags  (clr_flags),
        .tick_a     (tick_a),
        .tick_b_pre (tick_b_pre),
        .cnt_a      (cnt_a),
        .cnt_b      (cnt_b),
        .flag_a     (flag_a),
        .flag_b     (flag_b),
        .cmp_ff     (cmp_ff)
    );

    assign irq_a   = flag_a;
    assign irq_b   = flag_b;
    assign cmp_pin = cmp_ff && cfg_b.pin_en && !cfg_b.pwm_en;

    always_comb begin
        case (rd_addr)
            ADR_CFG_A: rd_data = CNT_W'(cfg_a);
            ADR_CFG_B: rd_data = CNT_W'(cfg_b);
            ADR_LIM_A: rd_data = lim_a;
            ADR_LIM_B: rd_data = lim_b;
            ADR_CNT_A: rd_data = cnt_a;
            ADR_CNT_B: rd_data = cnt_b;
            ADR_FLAG:  rd_data = CNT_W'({flag_b, flag_a});
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: tb/tmr_cascade_test.sv
`timescale 1ns/1ps
module tmr_cascade_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_evt = 1'b0;
    logic       irq_a, irq_b, cmp_pin;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tmr_cascade uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ext_evt (ext_evt),
        .irq_a   (irq_a),
        .irq_b   (irq_b),
        .cmp_pin (cmp_pin)
    );

    // Frequency vectors: source code, limit A, expected cycles between pin edges
    typedef struct packed {
        logic [2:0]  src;
        logic [7:0]  lim;
        logic [15:0] half;
    } fvec_t;

    localparam int NV = 8;
    localparam fvec_t FV [NV] = '{
        '{3'd0, 8'd3, 16'd8},
        '{3'd1, 8'd2, 16'd12},
        '{3'd2, 8'd0, 16'd8},
        '{3'd3, 8'd1, 16'd64},
        '{3'd4, 8'd0, 16'd128},
        '{3'd5, 8'd0, 16'd512},
        '{3'd6, 8'd0, 16'd2048},
        '{3'd0, 8'd0, 16'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ext_evt = 1'b1;
            repeat (4) @(negedge clk);
            ext_evt = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // Cycles until cmp_pin changes level; -1 on timeout
    task automatic edge_gap(output int n);
        logic prev;
        prev = cmp_pin;
        n = 0;
        while (cmp_pin == prev && n >= 0) begin
            @(negedge clk);
            n++;
            if (n > 5000) n = -1;
        end
    endtask

    // Stop and clear A, clear flags, load limit, then start A from the given source
    task automatic start_a(input logic [2:0] src, input logic [7:0] lim, input logic [7:0] cfgb);
        wr(3'd0, 8'h00);
        wr(3'd1, cfgb);
        wr(3'd6, 8'h03);
        wr(3'd2, lim);
        wr(3'd0, 8'h10 | {5'd0, src});
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int v, g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset values
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check($sformatf("R9 addr %0d", a), v, 0);
        end
        check("R9 irq_a", int'(irq_a), 0);
        check("R9 irq_b", int'(irq_b), 0);
        check("R9 cmp_pin", int'(cmp_pin), 0);

        // R4 / R7: compare pin spacing per source and limit (table walk)
        for (int i = 0; i < NV; i++) begin
            start_a(FV[i].src, FV[i].lim, 8'h40);
            edge_gap(g);
            edge_gap(g);
            check($sformatf("R4 R7 vector %0d", i), g, int'(FV[i].half));
        end

        // R8: pin gated off by pwm_en, by pin_en low, then on
        start_a(3'd0, 8'd0, 8'h60);
        v = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cmp_pin) v = 1;
        end
        check("R8 pwm_en blocks pin", v, 0);
        wr(3'd1, 8'h00);
        v = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cmp_pin) v = 1;
        end
        check("R8 pin_en low blocks pin", v, 0);
        wr(3'd1, 8'h40);
        edge_gap(g);
        check("R8 pin follows when enabled", int'(g > 0), 1);

        // R1: 8-bit counting and wrap from external edges
        start_a(3'd7, 8'd5, 8'h00);
        pulse(3);
        rd(3'd4, v); check("R1 count 3", v, 3);
        check("R1 no flag before match", int'(irq_a), 0);
        pulse(3);
        rd(3'd4, v); check("R1 wrap to 0", v, 0);
        check("R1 flag on match", int'(irq_a), 1);
        pulse(2);
        rd(3'd4, v); check("R1 count after wrap", v, 2);

        // R10: sticky flag, write 0 keeps, write 1 clears
        wr(3'd6, 8'h00);
        check("R10 write 0 keeps flag", int'(irq_a), 1);
        wr(3'd6, 8'h01);
        check("R10 write 1 clears flag", int'(irq_a), 0);

        // R12: count registers are read-only
        wr(3'd4, 8'h55);
        @(negedge clk);
        rd(3'd4, v); check("R12 count A unchanged", v, 2);

        // R5: hold, resume, clear
        wr(3'd0, 8'h0F);
        @(negedge clk);
        pulse(2);
        rd(3'd4, v); check("R5 hold keeps value", v, 2);
        wr(3'd0, 8'h1F);
        @(negedge clk);
        pulse(1);
        rd(3'd4, v); check("R5 resume from held", v, 3);
        wr(3'd0, 8'h07);
        repeat (2) @(negedge clk);
        rd(3'd4, v); check("R5 stop clears", v, 0);

        // R6: rewrite with run=1 keep=0 restarts
        wr(3'd0, 8'h17);
        @(negedge clk);
        pulse(4);
        rd(3'd4, v); check("R6 count before restart", v, 4);
        wr(3'd0, 8'h17);
        rd(3'd4, v); check("R6 restart clears", v, 0);
        @(negedge clk);
        pulse(1);
        rd(3'd4, v); check("R6 counts after restart", v, 1);

        // R2 / R3: 16-bit mode with joint limit 0x0102
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h01);
        start_a(3'd7, 8'h02, 8'h13);
        pulse(256);
        rd(3'd4, v); check("R2 low byte at 256", v, 0);
        rd(3'd5, v); check("R2 high byte at 256", v, 1);
        pulse(2);
        rd(3'd4, v); check("R2 low byte at 258", v, 2);
        check("R2 no flag before joint match", int'(irq_a), 0);
        pulse(1);
        rd(3'd4, v); check("R2 low byte wraps", v, 0);
        rd(3'd5, v); check("R2 high byte wraps", v, 0);
        check("R3 flag A set", int'(irq_a), 1);
        check("R3 flag B stays clear", int'(irq_b), 0);

        // R11: counter B counting matches of A
        wr(3'd3, 8'h01);
        start_a(3'd7, 8'h01, 8'h0B);
        pulse(2);
        rd(3'd5, v); check("R11 chained B after one A match", v, 1);
        check("R11 no B flag yet", int'(irq_b), 0);
        pulse(2);
        rd(3'd5, v); check("R11 chained B wraps", v, 0);
        check("R11 B flag on own match", int'(irq_b), 1);

        // R11: counter B on fclk/2 prescaler, limit 255, stopped holds a count
        wr(3'd6, 8'h03);
        wr(3'd3, 8'hFF);
        wr(3'd1, 8'h08);
        repeat (20) @(negedge clk);
        wr(3'd1, 8'h04);
        rd(3'd5, v);
        check("R11 B counts from prescaler", int'(v >= 8 && v <= 12), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule